// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block is the control unit of a multicycle processor, built as a small stored-program machine. A 4-bit micro-address register selects one of sixteen 18-bit microcode words. The upper sixteen bits of the selected word drive the datapath control lines directly. The lowest two bits choose where the sequencer goes next. It can go back to word 0, step to the following word, or jump through one of two 64-entry tables that are indexed by the 6-bit instruction opcode.

The next-state behaviour lives entirely in the stored words and the two tables. No next-state logic is hard-coded per state. The control contents come from a parameter. A write port can replace any word while the block runs, and a reset restores the parameter contents. Only ten words (0 to 9) are used by default. They form the fetch, decode, memory-address, memory-read, write-back, store, ALU, branch and jump steps.

Top module: `ucs_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the micro-address to 0 and restores every microcode word: bits 17:2 of word i from slice i of CTRL_INIT, and bits 1:0 from the default sequencing fields.
- R2: `ctrl` always equals bits 17:2 of the word at the current micro-address. It changes only when the micro-address changes or when that word is written.
- R3: A sequencing field of 2'b11 loads the current micro-address plus one (modulo 16). By default this is the field of words 0, 3 and 6.
- R4: A sequencing field of 2'b00 loads micro-address 0. By default this is the field of words 4, 5, 7, 8 and 9.
- R5: A field of 2'b01 (default in word 1) loads from table A: opcode 6'b100011 → 2, 6'b101011 → 2, 6'b000000 → 6, 6'b000100 → 8, 6'b000010 → 9.
- R6: A field of 2'b10 (default in word 2) loads from table B: opcode 6'b100011 → 3, 6'b101011 → 5.
- R7: An opcode that is not listed in the table being used yields micro-address 0.
- R8: Words 10 to 15 default to a sequencing field of 2'b00, so reaching any of them leads back to 0 on the next edge.
- R9: With wr_en high and rst low at a rising edge, word wr_addr takes wr_data. The next address computed in that same cycle still uses the old contents.
- R10: With default contents, the micro-address visits 0,1,2,3,4 for opcode 100011; 0,1,2,5 for 101011; 0,1,6,7 for 000000; 0,1,8 for 000100; and 0,1,9 for 000010. Each walk then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode used by the dispatch tables |
| wr_en | input | 1 | Microcode word write enable |
| wr_addr | input | 4 | Word index to write |
| wr_data | input | 18 | New word: bits 17:2 control, bits 1:0 sequencing field |
| ctrl | output | 16 | Datapath control signals of the current word |
| uaddr | output | 4 | Current micro-address |

## Verification
A wrong micro-address or a wrong sequencing decision shows on `uaddr` at the next clock edge. The wrong control word then shows on `ctrl` in the same cycle. Corrupted microcode shows on `ctrl` as soon as the bad word is addressed, and its sequencing field misdirects `uaddr` one edge later. The bench walks each opcode path and applies both valid and unlisted opcodes at both tables. It also writes words, including the current word, to confirm which contents steer each transition.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int UADDR_W = 4;
  localparam int CTRL_W  = 16;
  localparam int SEQ_W   = 2;
  localparam int OPC_W   = 6;
  localparam int WORD_W  = CTRL_W + SEQ_W;
  localparam int NWORDS  = 1 << UADDR_W;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_HOME   = 2'b00,
    SEQ_DISP_A = 2'b01,
    SEQ_DISP_B = 2'b10,
    SEQ_STEP   = 2'b11
  } seq_e;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ALU    = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;

  // Default sequencing field per word; unused words go home.
  function automatic seq_e seq_default(input int unsigned idx);
    case (idx)
      0, 3, 6: seq_default = SEQ_STEP;
      1:       seq_default = SEQ_DISP_A;
      2:       seq_default = SEQ_DISP_B;
      default: seq_default = SEQ_HOME;
    endcase
  endfunction

  // Table A: decode-time targets.
  function automatic logic [UADDR_W-1:0] disp_a_lookup(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LOAD, OPC_STORE: disp_a_lookup = 4'd2;
      OPC_ALU:             disp_a_lookup = 4'd6;
      OPC_BRANCH:          disp_a_lookup = 4'd8;
      OPC_JUMP:            disp_a_lookup = 4'd9;
      default:             disp_a_lookup = '0;
    endcase
  endfunction

  // Table B: memory-access split.
  function automatic logic [UADDR_W-1:0] disp_b_lookup(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LOAD:  disp_b_lookup = 4'd3;
      OPC_STORE: disp_b_lookup = 4'd5;
      default:   disp_b_lookup = '0;
    endcase
  endfunction

  function automatic logic [UADDR_W-1:0] uaddr_step(input logic [UADDR_W-1:0] a);
    uaddr_step = UADDR_W'(a + 1'b1);
  endfunction

  // Placeholder control pattern used when no contents are supplied.
  function automatic logic [NWORDS*CTRL_W-1:0] ctrl_pack_default();
    logic [NWORDS*CTRL_W-1:0] v;
    v = '0;
    for (int i = 0; i < NWORDS; i++) begin
      v[i*CTRL_W +: CTRL_W] = CTRL_W'(16'h0101 * i);
    end
    ctrl_pack_default = v;
  endfunction
endpackage

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
#(
  parameter logic [NWORDS*CTRL_W-1:0] CTRL_INIT = ctrl_pack_default()
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [UADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [UADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]  rd_word
);
  logic [WORD_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) begin
        mem[i] <= {CTRL_INIT[i*CTRL_W +: CTRL_W], SEQ_W'(seq_default(unsigned'(i)))};
      end
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/ucs_dispatch.sv
module ucs_dispatch
  import ucs_pkg::*;
#(
  parameter int TABLE_ID = 1
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] target
);
  generate
    if (TABLE_ID == 1) begin : g_table_a
      assign target = disp_a_lookup(opcode);
    end else begin : g_table_b
      assign target = disp_b_lookup(opcode);
    end
  endgenerate
endmodule

// File: rtl/ucs_next.sv
module ucs_next
  import ucs_pkg::*;
(
  input  logic [SEQ_W-1:0]   sel,
  input  logic [UADDR_W-1:0] cur,
  input  logic [UADDR_W-1:0] tgt_a,
  input  logic [UADDR_W-1:0] tgt_b,
  output logic [UADDR_W-1:0] nxt
);
  always_comb begin
    unique case (seq_e'(sel))
      SEQ_HOME:   nxt = '0;
      SEQ_DISP_A: nxt = tgt_a;
      SEQ_DISP_B: nxt = tgt_b;
      SEQ_STEP:   nxt = uaddr_step(cur);
      default:    nxt = '0;
    endcase
  end
endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
#(
  parameter logic [NWORDS*CTRL_W-1:0] CTRL_INIT = ctrl_pack_default()
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               wr_en,
  input  logic [UADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  ctrl,
  output logic [UADDR_W-1:0] uaddr
);
  logic [UADDR_W-1:0] upc;
  logic [UADDR_W-1:0] upc_next;
  logic [WORD_W-1:0]  cur_word;
  logic [SEQ_W-1:0]   seq_sel;
  logic [UADDR_W-1:0] disp_a_tgt;
  logic [UADDR_W-1:0] disp_b_tgt;

  ucs_store #(.CTRL_INIT(CTRL_INIT)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(upc), .rd_word(cur_word)
  );

  ucs_dispatch #(.TABLE_ID(1)) u_disp_a (.opcode(opcode), .target(disp_a_tgt));
  ucs_dispatch #(.TABLE_ID(2)) u_disp_b (.opcode(opcode), .target(disp_b_tgt));

  assign seq_sel = cur_word[SEQ_W-1:0];

  ucs_next u_next (
    .sel(seq_sel), .cur(upc), .tgt_a(disp_a_tgt), .tgt_b(disp_b_tgt), .nxt(upc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_next;
  end

  assign ctrl  = cur_word[WORD_W-1:SEQ_W];
  assign uaddr = upc;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker
  import ucs_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [OPC_W-1:0]   opcode,
  input logic               wr_en,
  input logic [UADDR_W-1:0] wr_addr,
  input logic [CTRL_W-1:0]  ctrl,
  input logic [UADDR_W-1:0] uaddr,
  input logic [SEQ_W-1:0]   seq_sel
);
  p_reset_home_r1: assert property (@(posedge clk) rst |=> (uaddr == '0));

  p_moore_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(uaddr) && !($past(wr_en) && $past(wr_addr) == uaddr))
      |-> $stable(ctrl));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b11) |=> (uaddr == UADDR_W'($past(uaddr) + 1'b1)));

  p_home_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b00) |=> (uaddr == '0));

  p_disp_alu_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b01 && opcode == 6'b000000) |=> (uaddr == 4'd6));

  p_disp_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b01 && opcode == 6'b000010) |=> (uaddr == 4'd9));

  p_disp_load_r6: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b10 && opcode == 6'b100011) |=> (uaddr == 4'd3));

  p_disp_miss_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b10 && opcode != 6'b100011 && opcode != 6'b101011) |=> (uaddr == '0));
endmodule

bind ucs_sequencer ucs_checker u_ucs_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl(ctrl), .uaddr(uaddr), .seq_sel(seq_sel)
);

// File: tb/test_ucs_sequencer.sv
`timescale 1ns/1ps
module test_ucs_sequencer;
  localparam real CLK_NS = 8.0;

  function automatic logic [15:0] b_ctrl(input int i);
    logic [3:0] k;
    k = 4'(i);
    b_ctrl = {k ^ 4'hC, 4'h3, ~k, k};
  endfunction

  function automatic logic [255:0] b_pack();
    for (int i = 0; i < 16; i++) b_pack[i*16 +: 16] = b_ctrl(i);
  endfunction

  function automatic logic [1:0] b_seq(input int i);
    if (i == 0 || i == 3 || i == 6) b_seq = 2'b11;
    else if (i == 1)                b_seq = 2'b01;
    else if (i == 2)                b_seq = 2'b10;
    else                            b_seq = 2'b00;
  endfunction

  function automatic logic [3:0] b_tab_a(input logic [5:0] op);
    if (op == 6'b100011 || op == 6'b101011) return 4'd2;
    if (op == 6'b000000) return 4'd6;
    if (op == 6'b000100) return 4'd8;
    if (op == 6'b000010) return 4'd9;
    return 4'd0;
  endfunction

  function automatic logic [3:0] b_tab_b(input logic [5:0] op);
    if (op == 6'b100011) return 4'd3;
    if (op == 6'b101011) return 4'd5;
    return 4'd0;
  endfunction

  logic        clk = 0;
  logic        rst = 1;
  logic [5:0]  opcode = '0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [15:0] ctrl;
  logic [3:0]  uaddr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_ctrl [16];
  logic [1:0]  m_seq  [16];
  logic [3:0]  m_state;

  always #(CLK_NS/2) clk = ~clk;

  ucs_sequencer #(.CTRL_INIT(b_pack())) i_ucs_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .uaddr(uaddr)
  );

  task automatic m_reset();
    for (int i = 0; i < 16; i++) begin
      m_ctrl[i] = b_ctrl(i);
      m_seq[i]  = b_seq(i);
    end
    m_state = 4'd0;
  endtask

  task automatic chk(input string tag);
    vectors++;
    if (uaddr !== m_state) begin
      fails++;
      $display("FAIL %s uaddr actual %0d expected %0d", tag, uaddr, m_state);
    end
    vectors++;
    if (ctrl !== m_ctrl[m_state]) begin
      fails++;
      $display("FAIL %s ctrl actual %h expected %h", tag, ctrl, m_ctrl[m_state]);
    end
  endtask

  task automatic expect_at(input logic [3:0] s, input string tag);
    vectors++;
    if (uaddr !== s) begin
      fails++;
      $display("FAIL %s state actual %0d expected %0d", tag, uaddr, s);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at the next negedge.
  task automatic tick(input logic rs, input logic we, input logic [3:0] wa,
                      input logic [17:0] wd, input string tag);
    logic [3:0] nxt;
    rst = rs; wr_en = we; wr_addr = wa; wr_data = wd;
    case (m_seq[m_state])
      2'b00:   nxt = 4'd0;
      2'b01:   nxt = b_tab_a(opcode);
      2'b10:   nxt = b_tab_b(opcode);
      default: nxt = m_state + 4'd1;
    endcase
    @(posedge clk);
    if (rs) m_reset();
    else begin
      if (we) begin
        m_ctrl[wa] = wd[17:2];
        m_seq[wa]  = wd[1:0];
      end
      m_state = nxt;
    end
    @(negedge clk);
    wr_en = 0;
    chk(tag);
  endtask

  task automatic run(input string tag);
    tick(0, 0, 4'd0, 18'd0, tag);
  endtask

  task automatic t_reset();
    m_reset();
    tick(1, 0, 4'd0, 18'd0, "R1 reset");
    tick(1, 1, 4'd3, 18'h3FFFF, "R1 reset beats write");
    expect_at(4'd0, "R1 home");
  endtask

  task automatic t_load();
    opcode = 6'b100011;
    run("R3 fetch step");      expect_at(4'd1, "R10 load");
    run("R5 table A load");    expect_at(4'd2, "R10 load");
    run("R6 table B load");    expect_at(4'd3, "R10 load");
    run("R3 read step");       expect_at(4'd4, "R10 load");
    run("R4 writeback home");  expect_at(4'd0, "R10 load");
  endtask

  task automatic t_store();
    opcode = 6'b101011;
    run("R10 store"); run("R5 table A store"); expect_at(4'd2, "R5");
    run("R6 table B store"); expect_at(4'd5, "R6");
    run("R4 store home"); expect_at(4'd0, "R4");
  endtask

  task automatic t_alu();
    opcode = 6'b000000;
    run("R10 alu"); run("R5 table A alu"); expect_at(4'd6, "R5");
    run("R3 alu step"); expect_at(4'd7, "R3");
    run("R4 alu home"); expect_at(4'd0, "R4");
  endtask

  task automatic t_branch_jump();
    opcode = 6'b000100;
    run("R10 branch"); run("R5 table A branch"); expect_at(4'd8, "R5");
    run("R4 branch home");
    opcode = 6'b000010;
    run("R10 jump"); run("R5 table A jump"); expect_at(4'd9, "R5");
    run("R4 jump home"); expect_at(4'd0, "R4");
  endtask

  task automatic t_unlisted();
    opcode = 6'b111111;
    run("R7 fetch"); run("R7 table A miss"); expect_at(4'd0, "R7");
    opcode = 6'b100011;
    run("R7 fetch"); run("R7 to word 2");
    opcode = 6'b000000;
    run("R7 table B miss"); expect_at(4'd0, "R7");
  endtask

  task automatic t_write();
    opcode = 6'b111111;
    tick(0, 1, 4'd5, {16'hBEEF, 2'b11}, "R2 write elsewhere leaves ctrl");
    run("R7 back home");
    opcode = 6'b101011;
    run("R9 fetch"); run("R9 decode");
    run("R9 new word 5");
    vectors++;
    if (ctrl !== 16'hBEEF) begin
      fails++;
      $display("FAIL R9 ctrl actual %h expected %h", ctrl, 16'hBEEF);
    end
    run("R9 new field steps"); expect_at(4'd6, "R9");
    run("R9 to 7"); run("R9 home");
  endtask

  task automatic t_unused();
    opcode = 6'b000010;
    tick(0, 1, 4'd9, {16'h0F0F, 2'b11}, "R9 write word 9");
    run("R9 to 9");
    run("R8 to unused 10"); expect_at(4'd10, "R8");
    run("R8 unused home"); expect_at(4'd0, "R8");
  endtask

  task automatic t_same_word();
    opcode = 6'b111111;
    tick(0, 1, 4'd0, {16'h1234, 2'b00}, "R9 old field used in write cycle");
    expect_at(4'd1, "R9");
    run("R9 home");
    run("R9 new field holds at 0"); expect_at(4'd0, "R9");
  endtask

  task automatic t_reload();
    tick(1, 0, 4'd0, 18'd0, "R1 reload");
    opcode = 6'b000010;
    run("R1 word 0 restored"); run("R1 to 9");
    run("R1 word 9 restored"); expect_at(4'd0, "R1");
    opcode = 6'b101011;
    run("R1"); run("R1"); run("R1 word 5 restored");
    run("R1 word 5 home"); expect_at(4'd0, "R1");
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_alu();
    t_branch_jump();
    t_unlisted();
    t_write();
    t_unused();
    t_same_word();
    t_reload();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule